// File: doc/BRIEF.md
# I/O Target Responder for a Low-Pin-Count Host Bus

This block sits on the peripheral side of a shared 4-bit multiplexed host bus framed by an active-low frame strobe. It follows every framed cycle nibble by nibble and claims only I/O read and I/O write cycles whose 16-bit address falls inside a window set by parameters. Once a cycle is claimed, the block takes the bus from the host, reports progress with sync codes, returns read data, and gives the bus back through a two-clock turnaround. Any cycle it does not claim leaves its drivers disabled for the whole cycle.

On the inside it offers a plain register port. Each claimed cycle produces a one-clock read or write strobe, together with the address and (for writes) the byte the host sent. The register file answers with a ready input and may hold that input low to add wait states. If ready does not arrive within a bounded number of clocks, the access ends with the error sync code, so the host never waits without limit.

Top module: `lpc_io_target`

## Requirements
- R1: While rst_n is low, and after it is released, bus_oe, reg_rd and reg_wr are 0 until a claimed cycle reaches its sync phase.
- R2: A cycle is decoded only when the nibble sampled on the last clock with frame_n low is 4'b0000 and the next nibble (frame_n high) has bits [3:1] equal to 3'b000 (I/O read) or 3'b001 (I/O write). Any other start or type nibble makes the target ignore the cycle: no drive and no strobe.
- R3: The address is taken from the next 4 nibbles, most significant nibble first, and is presented on reg_addr. The cycle is claimed only if ((addr ^ WIN_BASE) & WIN_MASK) == 0 (default window 0x0380 to 0x038F). Otherwise bus_oe stays 0.
- R4: For a write, the 2 nibbles after the address form reg_wdata, least significant nibble first. reg_wr pulses for exactly one clock, on the first sync clock.
- R5: For a read, reg_rd pulses for exactly one clock, on the first sync clock. The byte captured from reg_rdata is driven in the two clocks after sync 4'b0000, low nibble first.
- R6: In the sync phase the target drives the wait code 4'b0110 from the first sync clock through the clock in which reg_ready is sampled high, then drives 4'b0000 for one clock.
- R7: If reg_ready is not sampled high within TIMEOUT_CLKS (default 8) wait clocks, the target drives 4'b1010 for one clock, skips the data phase and goes to the final turnaround.
- R8: The target never drives during the host's address, data or two-clock turnaround nibbles. After its last sync or data nibble it drives 4'b1111 for one clock and then releases the bus.
- R9: frame_n low in any clock forces bus_oe to 0 in that same clock and starts decoding a new cycle.
- R10: bus_oe is 1 only during sync clocks, read data clocks and the first clock of the final turnaround.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising-edge sampled |
| rst_n | input | 1 | Active-low asynchronous bus reset |
| frame_n | input | 1 | Active-low cycle frame from the host |
| bus_in | input | 4 | Nibble sampled from the shared bus |
| bus_out | output | 4 | Nibble driven by the target |
| bus_oe | output | 1 | Enables the target's bus drivers |
| reg_addr | output | 16 | Address of the current access |
| reg_wr | output | 1 | One-clock write strobe |
| reg_wdata | output | 8 | Write byte |
| reg_rd | output | 1 | One-clock read strobe |
| reg_rdata | input | 8 | Read byte from the register file |
| reg_ready | input | 1 | Register file has completed the access |

## Verification
The bench checks that a START nibble only counts when it is the last one before frame_n rises. A design that latched the first low-frame nibble would claim a grant cycle, and one that latched a later nibble would miss a valid cycle. It checks the edges of the address window and cycle types that differ from I/O only in bit 2, where a loose decoder would drive the bus in another target's cycle. Ready in the same clock as the strobe, ready after several waits, and no ready at all are each compared clock by clock against the expected wait, ready, error, data and turnaround nibbles. An off-by-one timer or a data phase driven after the error code would show up there. An abort during the wait and a reset in the middle of a cycle must release the bus at once, and the cycle that follows must still complete.

// File: rtl/lpcio_pkg.sv
package lpcio_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_ADDR, PH_WDATA, PH_TARIN, PH_SYNC, PH_RDATA, PH_TAROUT
  } phase_t;

  typedef enum logic [1:0] { SY_WAIT, SY_OK, SY_ERR } sync_t;

  localparam logic [3:0] NIB_START   = 4'b0000;
  localparam logic [3:0] NIB_READY   = 4'b0000;
  localparam logic [3:0] NIB_ERROR   = 4'b1010;
  localparam logic [3:0] NIB_IDLE    = 4'b1111;
  localparam logic [3:0] NIB_LWAIT   = 4'b0110;
  localparam logic [3:0] NIB_SWAIT   = 4'b0101;

  function automatic logic ct_io_read(input logic [3:0] nib);
    return nib[3:1] == 3'b000;
  endfunction

  function automatic logic ct_io_write(input logic [3:0] nib);
    return nib[3:1] == 3'b001;
  endfunction

  function automatic logic in_window(input logic [15:0] a,
                                     input logic [15:0] base,
                                     input logic [15:0] mask);
    return ((a ^ base) & mask) == 16'h0000;
  endfunction

endpackage

// File: rtl/lpcio_window.sv
module lpcio_window #(
  parameter logic [15:0] BASE = 16'h0380,
  parameter logic [15:0] MASK = 16'hFFF0
) (
  input  logic [15:0] addr,
  output logic        hit
);
  assign hit = lpcio_pkg::in_window(addr, BASE, MASK);
endmodule

// File: rtl/lpcio_wait_timer.sv
module lpcio_wait_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
  import lpcio_pkg::*;
#(
  parameter logic [15:0] WIN_BASE     = 16'h0380,
  parameter logic [15:0] WIN_MASK     = 16'hFFF0,
  parameter int          TIMEOUT_CLKS = 8,
  parameter bit          LONG_WAIT    = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic [3:0]  bus_in,
  output logic [3:0]  bus_out,
  output logic        bus_oe,
  output logic [15:0] reg_addr,
  output logic        reg_wr,
  output logic [7:0]  reg_wdata,
  output logic        reg_rd,
  input  logic [7:0]  reg_rdata,
  input  logic        reg_ready
);
  localparam int ADDR_NIBS = 16 / 4;
  localparam logic [1:0] LAST_ADDR = 2'(ADDR_NIBS - 1);

  phase_t      st;
  sync_t       sy;
  logic [1:0]  cnt;
  logic        is_wr;
  logic        start_ok;
  logic        first_q;
  logic [15:0] addr_q;
  logic [7:0]  data_q;
  logic [3:0]  wait_nib;

  // Named internal events used by the checker
  logic [15:0] addr_next;
  logic        claim_hit;
  logic        wait_run;
  logic        wait_expired;
  logic        sync_ready;
  logic        sync_err;
  logic        oe_raw;

  generate
    if (LONG_WAIT) begin : g_long
      assign wait_nib = NIB_LWAIT;
    end else begin : g_short
      assign wait_nib = NIB_SWAIT;
    end
  endgenerate

  assign addr_next = {addr_q[11:0], bus_in};

  lpcio_window #(.BASE(WIN_BASE), .MASK(WIN_MASK)) win_i (
    .addr (addr_next),
    .hit  (claim_hit)
  );

  assign wait_run = (st == PH_SYNC) && (sy == SY_WAIT);

  lpcio_wait_timer #(.LIMIT(TIMEOUT_CLKS)) tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (wait_run),
    .expired (wait_expired)
  );

  assign sync_ready = wait_run && reg_ready;
  assign sync_err   = wait_run && !reg_ready && wait_expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PH_IDLE;
      sy       <= SY_WAIT;
      cnt      <= 2'd0;
      is_wr    <= 1'b0;
      start_ok <= 1'b0;
      first_q  <= 1'b0;
      addr_q   <= 16'h0000;
      data_q   <= 8'h00;
    end else if (!frame_n) begin
      st       <= PH_START;
      start_ok <= (bus_in == NIB_START);
      cnt      <= 2'd0;
      first_q  <= 1'b0;
    end else begin
      case (st)
        PH_IDLE: ;
        PH_START: begin
          cnt <= 2'd0;
          if (start_ok && ct_io_read(bus_in)) begin
            st <= PH_ADDR; is_wr <= 1'b0;
          end else if (start_ok && ct_io_write(bus_in)) begin
            st <= PH_ADDR; is_wr <= 1'b1;
          end else begin
            st <= PH_IDLE;
          end
        end
        PH_ADDR: begin
          addr_q <= addr_next;
          cnt    <= cnt + 2'd1;
          if (cnt == LAST_ADDR) begin
            cnt <= 2'd0;
            if (!claim_hit) st <= PH_IDLE;
            else if (is_wr) st <= PH_WDATA;
            else            st <= PH_TARIN;
          end
        end
        PH_WDATA: begin
          if (cnt == 2'd0) begin
            data_q[3:0] <= bus_in; cnt <= 2'd1;
          end else begin
            data_q[7:4] <= bus_in; cnt <= 2'd0; st <= PH_TARIN;
          end
        end
        PH_TARIN: begin
          if (cnt == 2'd0) cnt <= 2'd1;
          else begin
            cnt <= 2'd0; st <= PH_SYNC; sy <= SY_WAIT; first_q <= 1'b1;
          end
        end
        PH_SYNC: begin
          first_q <= 1'b0;
          case (sy)
            SY_WAIT: begin
              if (sync_ready) begin
                sy <= SY_OK;
                if (!is_wr) data_q <= reg_rdata;
              end else if (sync_err) begin
                sy <= SY_ERR;
              end
            end
            SY_OK:   st <= is_wr ? PH_TAROUT : PH_RDATA;
            default: st <= PH_TAROUT;
          endcase
        end
        PH_RDATA: begin
          if (cnt == 2'd0) cnt <= 2'd1;
          else begin cnt <= 2'd0; st <= PH_TAROUT; end
        end
        PH_TAROUT: begin
          if (cnt == 2'd0) cnt <= 2'd1;
          else begin cnt <= 2'd0; st <= PH_IDLE; end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    oe_raw  = 1'b0;
    bus_out = NIB_IDLE;
    case (st)
      PH_SYNC: begin
        oe_raw  = 1'b1;
        bus_out = (sy == SY_WAIT) ? wait_nib : (sy == SY_OK) ? NIB_READY : NIB_ERROR;
      end
      PH_RDATA: begin
        oe_raw  = 1'b1;
        bus_out = (cnt == 2'd0) ? data_q[3:0] : data_q[7:4];
      end
      PH_TAROUT: oe_raw = (cnt == 2'd0);
      default: ;
    endcase
  end

  assign bus_oe    = oe_raw && frame_n;
  assign reg_rd    = (st == PH_SYNC) && first_q && !is_wr && frame_n;
  assign reg_wr    = (st == PH_SYNC) && first_q &&  is_wr && frame_n;
  assign reg_addr  = addr_q;
  assign reg_wdata = data_q;

endmodule

// File: rtl/lpc_io_target_chk.sv
module lpc_io_target_chk #(
  parameter int TIMEOUT_CLKS = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic       bus_oe,
  input logic [3:0] bus_out,
  input logic       reg_rd,
  input logic       reg_wr,
  input logic       sync_ready,
  input logic       sync_err
);
  localparam int WW = $clog2(TIMEOUT_CLKS + 2) + 1;
  logic [WW-1:0] wait_seen;
  logic          wait_drive;

  assign wait_drive = bus_oe && (bus_out == 4'b0110 || bus_out == 4'b0101);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wait_seen <= '0;
    else if (!wait_drive) wait_seen <= '0;
    else if (wait_seen != '1) wait_seen <= wait_seen + WW'(1);
  end

  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |-> !bus_oe); // R9
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr)); // R4
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr); // R4
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd); // R5
  AST_FIRST_DRIVE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> (bus_out == 4'b0110 || bus_out == 4'b0101)); // R6
  AST_READY_TO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ready && frame_n) |=> (!frame_n || (bus_oe && bus_out == 4'b0000))); // R6
  AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err && frame_n) |=> (!frame_n || (bus_oe && bus_out == 4'b1010))); // R7
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wait_seen <= WW'(TIMEOUT_CLKS)); // R7
  AST_RELEASE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_oe) && frame_n) |-> $past(bus_out) == 4'b1111); // R8

endmodule

bind lpc_io_target lpc_io_target_chk #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_n    (frame_n),
  .bus_oe     (bus_oe),
  .bus_out    (bus_out),
  .reg_rd     (reg_rd),
  .reg_wr     (reg_wr),
  .sync_ready (sync_ready),
  .sync_err   (sync_err)
);

// File: tb/lpc_io_target_tb_top.sv
`timescale 1ns/1ps
module lpc_io_target_tb_top;
  localparam int TMO = 8;
  localparam int WIN = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  bus_in = 4'hF;
  logic [3:0]  bus_out;
  logic        bus_oe;
  logic [15:0] reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic        reg_rd;
  logic [7:0]  reg_rdata = 8'h00;
  logic        reg_ready = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit host_drive_seen;

  always #5 clk = ~clk;

  lpc_io_target #(.TIMEOUT_CLKS(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_ready(reg_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic f, input logic [3:0] n);
    @(negedge clk);
    frame_n = f;
    bus_in  = n;
    #1;
    if (bus_oe) host_drive_seen = 1'b1;
  endtask

  task automatic header(input bit wr, input logic [15:0] a, input logic [7:0] wd,
                        input int pre, input logic [3:0] st_nib, input logic [3:0] ct_nib);
    host_drive_seen = 1'b0;
    if (pre >= 0) step(1'b0, 4'(pre));
    step(1'b0, st_nib);
    step(1'b1, ct_nib);
    for (int i = 0; i < 4; i++) step(1'b1, a[15-4*i -: 4]);
    if (wr) begin step(1'b1, wd[3:0]); step(1'b1, wd[7:4]); end
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
  endtask

  // One full cycle; expected nibbles derive from R5..R8 and R10
  task automatic io_cycle(input string name, input bit wr, input logic [15:0] a,
                          input logic [7:0] wd, input int lat, input logic [7:0] rv,
                          input bit claim, input int pre, input logic [3:0] st_nib,
                          input logic [3:0] ct_nib);
    int n_rd, n_wr, strobe_k;
    logic [15:0] cap_addr;
    logic [7:0]  cap_wd;
    logic        e_oe;
    logic [3:0]  e_out;
    int          rdy_k;
    n_rd = 0; n_wr = 0; strobe_k = -1; cap_addr = '0; cap_wd = '0;
    header(wr, a, wd, pre, st_nib, ct_nib);
    chk(!host_drive_seen, {name, " R8 no drive in host nibbles"}, 32'(host_drive_seen), 0);
    rdy_k = (lat < TMO) ? lat + 1 : TMO;
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk);
      frame_n = 1'b1; bus_in = 4'hF; reg_ready = (k >= lat); reg_rdata = rv;
      #1;
      if (reg_rd) begin n_rd++; strobe_k = k; end
      if (reg_wr) begin n_wr++; strobe_k = k; end
      if (k == 0) begin cap_addr = reg_addr; cap_wd = reg_wdata; end
      e_oe = 1'b0; e_out = 4'hF;
      if (claim) begin
        if (k < rdy_k) begin e_oe = 1'b1; e_out = 4'b0110; end
        else if (k == rdy_k) begin e_oe = 1'b1; e_out = (lat < TMO) ? 4'b0000 : 4'b1010; end
        else if (lat < TMO && !wr && k == rdy_k + 1) begin e_oe = 1'b1; e_out = rv[3:0]; end
        else if (lat < TMO && !wr && k == rdy_k + 2) begin e_oe = 1'b1; e_out = rv[7:4]; end
        else if (k == rdy_k + ((lat < TMO && !wr) ? 3 : 1)) begin e_oe = 1'b1; e_out = 4'hF; end
      end
      chk(bus_oe == e_oe, {name, " R10 oe per clock"}, {k[15:0], 15'd0, bus_oe}, {k[15:0], 15'd0, e_oe});
      if (e_oe && bus_oe)
        chk(bus_out == e_out, {name, " R6 R7 R5 R8 nibble"}, {k[15:0], 12'd0, bus_out}, {k[15:0], 12'd0, e_out});
    end
    reg_ready = 1'b0;
    if (claim) begin
      chk((wr ? n_wr : n_rd) == 1 && strobe_k == 0 && (wr ? n_rd : n_wr) == 0,
          {name, wr ? " R4 single write strobe" : " R5 single read strobe"},
          32'(strobe_k), 0);
      chk(cap_addr == a, {name, " R3 address"}, 32'(cap_addr), 32'(a));
      if (wr) chk(cap_wd == wd, {name, " R4 write data"}, 32'(cap_wd), 32'(wd));
    end else begin
      chk(n_rd == 0 && n_wr == 0, {name, " R2 R3 no strobe when ignored"}, 32'(n_rd + n_wr), 0);
    end
  endtask

  task automatic t_reset;
    #1;
    chk(!bus_oe && !reg_rd && !reg_wr, "R1 outputs in reset", {bus_oe, reg_rd, reg_wr}, 0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(!bus_oe && !reg_rd && !reg_wr, "R1 outputs after reset", {bus_oe, reg_rd, reg_wr}, 0);
  endtask

  task automatic t_abort;
    header(1'b0, 16'h0381, 8'h00, -1, 4'h0, 4'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); frame_n = 1'b1; bus_in = 4'hF; reg_ready = 1'b0; #1;
      chk(bus_oe, "R9 driving before abort", 32'(bus_oe), 1);
    end
    @(negedge clk); frame_n = 1'b0; bus_in = 4'h0; #1;
    chk(!bus_oe, "R9 release in abort clock", 32'(bus_oe), 0);
    io_cycle("after abort R9", 1'b0, 16'h0382, 8'h00, 1, 8'h5A, 1'b1, -1, 4'h0, 4'h0);
  endtask

  task automatic t_mid_reset;
    header(1'b1, 16'h0384, 8'h11, -1, 4'h0, 4'h2);
    @(negedge clk); frame_n = 1'b1; bus_in = 4'hF; #1;
    chk(bus_oe, "R1 driving before reset", 32'(bus_oe), 1);
    rst_n = 1'b0; #1;
    chk(!bus_oe && !reg_wr, "R1 reset releases bus", {bus_oe, reg_wr}, 0);
    @(negedge clk); rst_n = 1'b1;
    io_cycle("after reset R1", 1'b1, 16'h038A, 8'hC3, 0, 8'h00, 1'b1, -1, 4'h0, 4'h2);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    t_reset();
    io_cycle("write lat2",     1'b1, 16'h0385, 8'hA5, 2,  8'h00, 1'b1, -1, 4'h0, 4'h2);
    io_cycle("read lat0",      1'b0, 16'h038F, 8'h00, 0,  8'h3C, 1'b1, -1, 4'h0, 4'h0);
    io_cycle("read lat3 R5",   1'b0, 16'h0380, 8'h00, 3,  8'h96, 1'b1, -1, 4'h0, 4'h1);
    io_cycle("read lat7 R6",   1'b0, 16'h0386, 8'h00, 7,  8'hE1, 1'b1, -1, 4'h0, 4'h0);
    io_cycle("read timeout R7",1'b0, 16'h0387, 8'h00, 99, 8'hFF, 1'b1, -1, 4'h0, 4'h0);
    io_cycle("write timeout R7",1'b1,16'h0388, 8'h42, 99, 8'h00, 1'b1, -1, 4'h0, 4'h3);
    io_cycle("above window R3",1'b0, 16'h0390, 8'h00, 0,  8'h77, 1'b0, -1, 4'h0, 4'h0);
    io_cycle("below window R3",1'b1, 16'h037F, 8'h12, 0,  8'h00, 1'b0, -1, 4'h0, 4'h2);
    io_cycle("high addr R3",   1'b0, 16'h1380, 8'h00, 0,  8'h77, 1'b0, -1, 4'h0, 4'h0);
    io_cycle("mem read R2",    1'b0, 16'h0380, 8'h00, 0,  8'h77, 1'b0, -1, 4'h0, 4'h4);
    io_cycle("mem write R2",   1'b0, 16'h0380, 8'h00, 0,  8'h77, 1'b0, -1, 4'h0, 4'h6);
    io_cycle("grant start R2", 1'b0, 16'h0380, 8'h00, 0,  8'h77, 1'b0, -1, 4'h2, 4'h0);
    io_cycle("last start R2",  1'b0, 16'h0383, 8'h00, 1,  8'h2B, 1'b1,  2, 4'h0, 4'h0);
    io_cycle("stale start R2", 1'b0, 16'h0383, 8'h00, 1,  8'h2B, 1'b0,  0, 4'hD, 4'h0);
    t_abort();
    t_mid_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule